// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block is the clocked decision logic for one phase of a synchronous buck converter. It decides, cycle by cycle, whether the gate enable for the high-side switch (`hs_on`) or for the low-side switch (`ls_on`) is asserted. Analog front ends have already decoded the three-level PWM command and the three-level enable into two-bit codes. They also supply a supply-good flag, two gate-sense comparator flags and a zero-cross comparator flag.

Dead time is adaptive. When one output turns off, the other output turns on only after a sense flag shows that the first gate has actually discharged, followed by a fixed propagation delay. A timeout makes sure the sequence never stalls. A mid PWM level selects diode emulation. In that mode the high side stays off and the low side turns on. The low side is held on through a blanking window. After the window, the first zero-cross flag turns the low side off, and it stays off until PWM leaves mid.

Both outputs are registered. A change on any input shows at the outputs at the earliest on the next clock edge.

Top module: `buck_gate_seq`

## Requirements
- R1: While `supply_ok` is 0, both outputs are 0 from the next edge on. After `supply_ok` rises, PWM regains control through the normal dead-time sequence.
- R2: An enable code other than high (2'b10) forces both outputs to 0 at the next edge. Low is 2'b00 and mid is 2'b01.
- R3: PWM high (2'b10) clears `ls_on` at the next edge. `hs_on` rises NOVL_PROP_CYC edges after the first edge, following entry into the wait, at which `lo_gate_low` is sampled high.
- R4: PWM low (2'b00) clears `hs_on` at the next edge. `ls_on` rises NOVL_PROP_CYC edges after the first edge, following entry into the wait, at which `hi_gate_low` is sampled high.
- R5: PWM mid (2'b01) from the high-side-on state clears `hs_on` at the next edge. `ls_on` then rises after the same wait as in R4.
- R6: After `ls_on` rises in diode emulation, `zero_cross` has no effect for BLANK_CYC edges, so `ls_on` stays high for at least BLANK_CYC+1 edges.
- R7: After blanking, the first edge that samples `zero_cross` high clears `ls_on`. It stays 0 while PWM remains mid, even after `zero_cross` falls.
- R8: PWM low after a zero-cross turn-off sets `ls_on` at the next edge.
- R9: If the sense flag never arrives, the pending output rises NOVL_TIMEOUT_CYC+NOVL_PROP_CYC edges after entry into the wait.
- R10: `hs_on` and `ls_on` are never both 1.
- R11: The PWM code 2'b11 forces both outputs to 0 at the next edge.
- R12: Each entry into diode emulation restarts blanking. Going from low-side-on to mid keeps `ls_on` high with no gap, and `ls_on` falls BLANK_CYC+1 edges after entry when `zero_cross` is already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_lvl | input | 2 | Decoded PWM: 00 low, 01 mid, 10 high, 11 illegal |
| en_lvl | input | 2 | Decoded enable: 00 low, 01 mid, 10 high, 11 illegal |
| supply_ok | input | 1 | Supply above lockout threshold |
| lo_gate_low | input | 1 | Low-side gate below threshold |
| hi_gate_low | input | 1 | High-side gate-to-switch below threshold |
| zero_cross | input | 1 | Inductor current zero-cross detected |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |

## Verification
The dead-time path is swept in both directions over every delay of the sense flag, from the first sampling edge up to past the timeout. The measured latency therefore shows where the flag is respected and where the timeout takes over. Every combination of supply flag, enable code and PWM code is applied from both a high-side-on state and a low-side-on state, which separates the lockout, disable and illegal-code paths. In diode emulation the zero-cross arrival is swept across the blanking boundary, to check that an early flag is ignored and a late flag is obeyed. That sweep is followed by the hold-low, re-latch and re-entry sequences.

// File: rtl/bgs_pkg.sv
// Shared types for the buck gate sequencer.
// Assumes the analog decoders deliver the two-bit codes listed below.
package bgs_pkg;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_MID  = 2'b01,
        LVL_HIGH = 2'b10,
        LVL_BAD  = 2'b11
    } lvl_e;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_WAIT_HS,
        ST_HS_ON,
        ST_WAIT_LS,
        ST_LS_ON,
        ST_WAIT_DE,
        ST_DE_BLANK,
        ST_DE_ZC,
        ST_DE_DONE
    } state_e;

endpackage

// File: rtl/bgs_qual.sv
// Qualifies the run conditions for the sequencer.
// Lockout, any enable code other than high, or an illegal PWM code force the off state.
// Assumes the inputs are already synchronous to clk.
module bgs_qual
    import bgs_pkg::*;
(
    input  logic [1:0] pwm_lvl,
    input  logic [1:0] en_lvl,
    input  logic       supply_ok,
    output logic       force_off,
    output lvl_e       tgt
);

    // Decode the force condition and pass the PWM target through as an enum.
    always_comb begin
        tgt       = lvl_e'(pwm_lvl);
        force_off = !supply_ok || (lvl_e'(en_lvl) != LVL_HIGH) || (tgt == LVL_BAD);
    end

endmodule

// File: rtl/bgs_novl_timer.sv
// Adaptive non-overlap timer.
// While run is high it waits for the sense flag, or for the timeout, and then counts PROP_CYC cycles.
// done is high in the last of those cycles. clr restarts the whole sequence.
// Assumes PROP_CYC >= 1 and TIMEOUT_CYC >= 1.
module bgs_novl_timer #(
    parameter int unsigned TIMEOUT_CYC = 64,
    parameter int unsigned PROP_CYC    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic sense,
    output logic done
);

    localparam int unsigned LIM = (TIMEOUT_CYC > PROP_CYC) ? TIMEOUT_CYC : PROP_CYC;
    localparam int unsigned CW  = $clog2(LIM + 1);

    logic          seen_q;
    logic [CW-1:0] cnt_q;
    logic          to_hit;

    assign to_hit = (cnt_q == CW'(TIMEOUT_CYC - 1));
    assign done   = run && seen_q && (cnt_q == CW'(PROP_CYC - 1));

    // Wait phase until sense or timeout, then propagation-delay phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            seen_q <= 1'b0;
            cnt_q  <= '0;
        end else if (run) begin
            if (!seen_q) begin
                if (sense || to_hit) begin
                    seen_q <= 1'b1;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (!done) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_TIMEOUT_ENDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr && !seen_q && to_hit) |=> seen_q); // R9

endmodule

// File: rtl/bgs_blank_timer.sv
// Blanking timer for diode emulation.
// expired goes high after run has been high for BLANK_CYC-1 cycles since the last clr.
// Assumes BLANK_CYC >= 1.
module bgs_blank_timer #(
    parameter int unsigned BLANK_CYC = 35
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);

    localparam int unsigned BW = $clog2(BLANK_CYC + 1);

    logic [BW-1:0] cnt_q;

    assign expired = run && (cnt_q == BW'(BLANK_CYC - 1));

    // Count blanking cycles, holding at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_BLANK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr && !expired) |=> (cnt_q != '0)); // R6

endmodule

// File: rtl/buck_gate_seq.sv
// Gate-enable sequencer for one synchronous buck phase.
// Drives registered high-side and low-side enables with adaptive dead time,
// diode emulation (blanking plus zero-cross turn-off) and lockout or disable forcing.
// Assumes all inputs are synchronous to clk. Analog sensing lies outside this block.
module buck_gate_seq
    import bgs_pkg::*;
#(
    parameter int unsigned BLANK_CYC        = 35,
    parameter int unsigned NOVL_TIMEOUT_CYC = 64,
    parameter int unsigned NOVL_PROP_CYC    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pwm_lvl,
    input  logic [1:0] en_lvl,
    input  logic       supply_ok,
    input  logic       lo_gate_low,
    input  logic       hi_gate_low,
    input  logic       zero_cross,
    output logic       hs_on,
    output logic       ls_on
);

    state_e st_q, st_d;
    lvl_e   tgt;
    logic   force_off;
    logic   st_chg;
    logic   in_wait;
    logic   sense_sel;
    logic   novl_done;
    logic   blank_exp;
    logic   hs_q, ls_q;

    bgs_qual u_qual (
        .pwm_lvl   (pwm_lvl),
        .en_lvl    (en_lvl),
        .supply_ok (supply_ok),
        .force_off (force_off),
        .tgt       (tgt)
    );

    assign st_chg    = (st_d != st_q);
    assign in_wait   = (st_q == ST_WAIT_HS) || (st_q == ST_WAIT_LS) || (st_q == ST_WAIT_DE);
    assign sense_sel = (st_q == ST_WAIT_HS) ? lo_gate_low : hi_gate_low;

    bgs_novl_timer #(
        .TIMEOUT_CYC (NOVL_TIMEOUT_CYC),
        .PROP_CYC    (NOVL_PROP_CYC)
    ) u_novl (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (st_chg),
        .run   (in_wait),
        .sense (sense_sel),
        .done  (novl_done)
    );

    bgs_blank_timer #(
        .BLANK_CYC (BLANK_CYC)
    ) u_blank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (st_chg),
        .run     (st_q == ST_DE_BLANK),
        .expired (blank_exp)
    );

    // Next-state selection: forcing first, then the PWM target.
    always_comb begin
        st_d = st_q;
        if (force_off) begin
            st_d = ST_OFF;
        end else begin
            case (tgt)
                LVL_HIGH: begin
                    if (st_q == ST_WAIT_HS) begin
                        if (novl_done) st_d = ST_HS_ON;
                    end else if (st_q != ST_HS_ON) begin
                        st_d = ST_WAIT_HS;
                    end
                end
                LVL_LOW: begin
                    case (st_q)
                        ST_LS_ON:   st_d = ST_LS_ON;
                        ST_WAIT_LS: if (novl_done) st_d = ST_LS_ON;
                        ST_DE_BLANK, ST_DE_ZC, ST_DE_DONE: st_d = ST_LS_ON;
                        default:    st_d = ST_WAIT_LS;
                    endcase
                end
                LVL_MID: begin
                    case (st_q)
                        ST_LS_ON:    st_d = ST_DE_BLANK;
                        ST_WAIT_DE:  if (novl_done) st_d = ST_DE_BLANK;
                        ST_DE_BLANK: if (blank_exp) st_d = ST_DE_ZC;
                        ST_DE_ZC:    if (zero_cross) st_d = ST_DE_DONE;
                        ST_DE_DONE:  st_d = ST_DE_DONE;
                        default:     st_d = ST_WAIT_DE;
                    endcase
                end
                default: st_d = ST_OFF;
            endcase
        end
    end

    // State and registered gate enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_OFF;
            hs_q <= 1'b0;
            ls_q <= 1'b0;
        end else begin
            st_q <= st_d;
            hs_q <= (st_d == ST_HS_ON);
            ls_q <= (st_d == ST_LS_ON) || (st_d == ST_DE_BLANK) || (st_d == ST_DE_ZC);
        end
    end

    assign hs_on = hs_q;
    assign ls_on = ls_q;

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on && ls_on)); // R10
    AST_LOCKOUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!hs_on && !ls_on)); // R1
    AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (en_lvl != 2'b10) |=> (!hs_on && !ls_on)); // R2
    AST_ILLEGAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_lvl == 2'b11) |=> (!hs_on && !ls_on)); // R11
    AST_HS_AFTER_LS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_on) |-> !$past(ls_on)); // R3
    AST_LS_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_on) |-> !$past(hs_on)); // R4
    AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DE_BLANK && !force_off && pwm_lvl == 2'b01) |=> ls_on); // R6
    AST_ZC_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DE_DONE && !force_off && pwm_lvl == 2'b01) |=> !ls_on); // R7
    AST_LOW_RELATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DE_DONE && !force_off && pwm_lvl == 2'b00) |=> ls_on); // R8

endmodule

// File: tb/buck_gate_seq_bench.sv
module buck_gate_seq_bench;

    localparam int BLANK = 5;
    localparam int TO    = 8;
    localparam int PROP  = 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] pwm, en;
    logic       sup, lo_s, hi_s, zc;
    logic       hs, ls;

    int n_chk  = 0;
    int n_fail = 0;
    int n_ovl  = 0;
    bit fin    = 1'b0;

    always #10 clk = ~clk;

    buck_gate_seq #(
        .BLANK_CYC        (BLANK),
        .NOVL_TIMEOUT_CYC (TO),
        .NOVL_PROP_CYC    (PROP)
    ) u_buck_gate_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwm_lvl     (pwm),
        .en_lvl      (en),
        .supply_ok   (sup),
        .lo_gate_low (lo_s),
        .hi_gate_low (hi_s),
        .zero_cross  (zc),
        .hs_on       (hs),
        .ls_on       (ls)
    );

    // R10 monitor: sample away from the active edge
    always @(negedge clk) if (rst_n === 1'b1 && hs === 1'b1 && ls === 1'b1) n_ovl++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; pwm = 2'b00; en = 2'b00; sup = 1'b0;
        lo_s = 1'b0; hi_s = 1'b0; zc = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    task automatic go_hs();
        pwm = 2'b10; en = 2'b10; sup = 1'b1; lo_s = 1'b1;
        repeat (10) tick();
    endtask

    task automatic go_ls();
        pwm = 2'b00; en = 2'b10; sup = 1'b1; hi_s = 1'b1;
        repeat (10) tick();
    endtask

    // Wait for the selected output to rise; raise the selected flag after iteration d+1
    task automatic measure(input bit out_ls, input bit flag_hi, input int d,
                           input string req, output int found);
        found = 0;
        for (int i = 1; i <= 40; i++) begin
            tick();
            if (i == 1) chk((out_ls ? hs : ls) == 1'b0, req, int'(out_ls ? hs : ls), 0);
            if ((out_ls ? ls : hs) == 1'b1) begin
                found = i;
                break;
            end
            if (i == d + 1) begin
                if (flag_hi) hi_s = 1'b1; else lo_s = 1'b1;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int got, bad, exp;
        string rq;

        // reset state
        do_reset();
        chk(hs == 1'b0 && ls == 1'b0, "R1 reset", int'({hs, ls}), 0);

        // R1: lockout holds both low, then recovery through the dead-time path
        do_reset();
        pwm = 2'b10; en = 2'b10; lo_s = 1'b1; hi_s = 1'b1;
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (hs || ls) bad++;
        end
        chk(bad == 0, "R1 lockout", bad, 0);
        sup = 1'b1;
        measure(1'b0, 1'b0, 0, "R1", got);
        chk(got == PROP + 2, "R1 recover", got, PROP + 2);

        // R2: enable low and mid disable within one edge, then recover
        for (int e = 0; e < 2; e++) begin
            do_reset();
            go_hs();
            en = 2'(e);
            tick();
            chk(hs == 1'b0 && ls == 1'b0, "R2 disable", int'({hs, ls}), 0);
            bad = 0;
            for (int i = 0; i < 5; i++) begin
                tick();
                if (hs || ls) bad++;
            end
            chk(bad == 0, "R2 hold", bad, 0);
            en = 2'b10;
            measure(1'b0, 1'b0, 0, "R2", got);
            chk(got == PROP + 2, "R2 re-enable", got, PROP + 2);
        end

        // R1 R2 R11: exhaustive forced combinations from both on-states
        for (int st = 0; st < 2; st++) begin
            for (int p = 0; p < 4; p++) begin
                for (int e = 0; e < 4; e++) begin
                    for (int s = 0; s < 2; s++) begin
                        if (s == 1 && e == 2 && p != 3) continue;
                        do_reset();
                        if (st == 0) go_hs(); else go_ls();
                        pwm = 2'(p); en = 2'(e); sup = 1'(s);
                        tick();
                        rq = (p == 3) ? "R11" : ((s == 0) ? "R1" : "R2");
                        chk(hs == 1'b0 && ls == 1'b0, rq, int'({hs, ls}), 0);
                    end
                end
            end
        end

        // R3 R9: high-side turn-on latency versus low-side sense delay
        for (int d = 0; d <= TO + 2; d++) begin
            do_reset();
            go_ls();
            lo_s = 1'b0; hi_s = 1'b0;
            pwm = 2'b10;
            exp = ((d + 1 < TO) ? d + 1 : TO) + PROP + 1;
            rq = (d + 1 > TO) ? "R9" : "R3";
            measure(1'b0, 1'b0, d, rq, got);
            chk(got == exp, rq, got, exp);
        end

        // R4 R9: low-side turn-on latency versus high-side sense delay
        for (int d = 0; d <= TO + 2; d++) begin
            do_reset();
            go_hs();
            lo_s = 1'b0; hi_s = 1'b0;
            pwm = 2'b00;
            exp = ((d + 1 < TO) ? d + 1 : TO) + PROP + 1;
            rq = (d + 1 > TO) ? "R9" : "R4";
            measure(1'b1, 1'b1, d, rq, got);
            chk(got == exp, rq, got, exp);
        end

        // R5: mid from high-side-on uses the same adaptive wait
        do_reset();
        go_hs();
        lo_s = 1'b0; hi_s = 1'b0;
        pwm = 2'b01;
        measure(1'b1, 1'b1, 1, "R5", got);
        chk(got == PROP + 3, "R5", got, PROP + 3);

        // R6 R7 R8: zero-cross arrival swept across the blanking boundary
        for (int z = 1; z <= BLANK + 3; z++) begin
            int fall;
            do_reset();
            go_hs();
            hi_s = 1'b1;
            pwm = 2'b01;
            measure(1'b1, 1'b1, 0, "R5", got);
            fall = 0;
            if (z == 1) zc = 1'b1;
            for (int j = 1; j <= BLANK + 6; j++) begin
                tick();
                if (ls == 1'b0 && fall == 0) fall = j;
                if (j == z - 1) zc = 1'b1;
            end
            exp = (z > BLANK + 1) ? z : BLANK + 1;
            rq = (z <= BLANK) ? "R6" : "R7";
            chk(fall == exp, rq, fall, exp);
            zc = 1'b0;
            bad = 0;
            for (int i = 0; i < 10; i++) begin
                tick();
                if (ls) bad++;
            end
            chk(bad == 0, "R7 hold", bad, 0);
            pwm = 2'b00;
            tick();
            chk(ls == 1'b1, "R8", int'(ls), 1);
        end

        // R12: re-entry from low-side-on restarts blanking without a gap
        do_reset();
        go_ls();
        for (int rep = 0; rep < 2; rep++) begin
            int fall;
            zc = 1'b1;
            pwm = 2'b01;
            fall = 0;
            bad = 0;
            for (int i = 1; i <= BLANK + 4; i++) begin
                tick();
                if (ls == 1'b0 && fall == 0) fall = i;
                if (i <= BLANK + 1 && ls == 1'b0) bad++;
            end
            chk(bad == 0, "R12 no gap", bad, 0);
            chk(fall == BLANK + 2, "R12 restart", fall, BLANK + 2);
            pwm = 2'b00;
            tick();
            chk(ls == 1'b1, "R8 relatch", int'(ls), 1);
        end

        // R10: no overlap seen anywhere
        chk(n_ovl == 0, "R10", n_ovl, 0);

        fin = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule